// File: doc/BRIEF.md
# Dual Channel Pulse Burst Generator

This block drives two independent pulse outputs. Each channel produces a high phase and then a low phase, and it repeats that pair. Both phase lengths are counted in time units. One unit is a fixed number of system clocks, which by default gives 100 microseconds at 125 MHz. A channel either runs without end or stops after a programmed number of high pulses and then raises its done flag.

A host configures the block with single-cycle command writes. Each write carries an 8-bit command code and a 16-bit value. Each channel has its own codes for high length, low length and pulse count. One further code writes a shared two-bit enable mask. A separate query port takes any command code and returns the stored setting for that code in the same cycle.

Settings are latched into a channel only when its enable bit rises. The host therefore disarms a channel, rewrites its settings and then arms it again.

Top module: `dual_pulse_burst`

## Requirements
- R1: After reset both outputs and both done flags are low, the enable mask is 0, every stored high and low length reads back as 1, and every pulse count reads back as 0.
- R2: Codes 0x10 and 0x12 set the high length of channel 0 and channel 1, codes 0x11 and 0x13 set their low lengths, and codes 0x14 and 0x15 set their pulse counts. The stored value reads back on `query_data` for the same code from the cycle after the write strobe.
- R3: A length write with value 0 is stored as 1. Lengths otherwise range from 1 to 0xFFFF.
- R4: Code 0x1F stores `cmd_val[1:0]` as the enable mask, with bit 0 for channel 0 and bit 1 for channel 1. Querying 0x1F returns the mask in bits 1:0 and zeros above.
- R5: When a channel's enable bit goes from 0 to 1, its output is high one clock after the mask register updates. The high phase lasts high-length × TICK_CYCLES clocks, and the low phase that follows lasts low-length × TICK_CYCLES clocks.
- R6: A pulse count of 0 makes the channel alternate high and low phases for as long as it stays enabled.
- R7: A nonzero pulse count N gives exactly N high pulses. The output then stays low and the done flag is set at the end of the Nth high phase.
- R8: Clearing an enable bit forces that output low in the cycle after the strobe and clears its done flag one cycle later. Enabling the channel again restarts it with a high phase and a full pulse count.
- R9: Length and count writes made while a channel runs do not alter its current timing. They take effect at the channel's next enable.
- R10: The two channels run independently. Writes to one channel's settings do not change the other channel's settings or output.
- R11: A write strobe with any other code changes no stored setting and no output, and querying such a code returns 0.
- R12: One time unit equals TICK_CYCLES clocks, counted from the clock edge on which the channel starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe, one cycle |
| cmd_code | input | 8 | Command code |
| cmd_val | input | 16 | Command value |
| query_code | input | 8 | Code whose stored setting is read back |
| query_data | output | 16 | Stored setting for `query_code` (combinational) |
| pulse_out | output | 2 | Pulse outputs, bit n is channel n |
| burst_done | output | 2 | Burst finished flags, bit n is channel n |

## Verification
Stored settings and the mask register change on the edge that samples the strobe. Readback is combinational, so the bench samples it at the falling edge right after that edge. An output goes low at that same sample when its channel is disabled. It goes high one edge later when the channel is enabled, and the done flag clears one edge after a disable. The bench samples at those exact falling edges. Phase lengths are measured by counting consecutive falling-edge samples at one level, and that count must equal length × TICK_CYCLES exactly. Burst pulse counts are taken over a fixed window longer than the burst.

// File: rtl/pulse_burst_pkg.sv
package pulse_burst_pkg;
  localparam int unsigned NCH    = 2;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned VAL_W  = 16;

  localparam logic [CODE_W-1:0] CODE_HI_BASE  = 8'h10;
  localparam logic [CODE_W-1:0] CODE_LO_BASE  = 8'h11;
  localparam logic [CODE_W-1:0] CODE_CNT_BASE = 8'h14;
  localparam logic [CODE_W-1:0] CODE_MASK     = 8'h1F;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2,
    PH_DONE = 2'd3
  } phase_t;

  function automatic logic [CODE_W-1:0] hi_code(input int ch);
    return CODE_HI_BASE + CODE_W'(2 * ch);
  endfunction

  function automatic logic [CODE_W-1:0] lo_code(input int ch);
    return CODE_LO_BASE + CODE_W'(2 * ch);
  endfunction

  function automatic logic [CODE_W-1:0] cnt_code(input int ch);
    return CODE_CNT_BASE + CODE_W'(ch);
  endfunction

  // a length of zero is meaningless; the shortest phase is one unit
  function automatic logic [VAL_W-1:0] clamp_len(input logic [VAL_W-1:0] v);
    return (v == '0) ? VAL_W'(1) : v;
  endfunction

  // true when the high phase now ending is the last one of a finite burst
  function automatic logic last_pulse(input logic [VAL_W-1:0] limit,
                                      input logic [VAL_W-1:0] emitted);
    return (limit != '0) && (emitted == limit - VAL_W'(1));
  endfunction

  function automatic logic known_code(input logic [CODE_W-1:0] c);
    logic hit;
    hit = (c == CODE_MASK);
    for (int ch = 0; ch < NCH; ch++) begin
      hit = hit | (c == hi_code(ch)) | (c == lo_code(ch)) | (c == cnt_code(ch));
    end
    return hit;
  endfunction
endpackage

// File: rtl/unit_prescaler.sv
module unit_prescaler #(
  parameter int unsigned TICK_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import pulse_burst_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_wr,
  input  logic [CODE_W-1:0]              cmd_code,
  input  logic [VAL_W-1:0]               cmd_val,
  input  logic [CODE_W-1:0]              query_code,
  output logic [VAL_W-1:0]               query_data,
  output logic [NCH-1:0][VAL_W-1:0]      hi_cfg,
  output logic [NCH-1:0][VAL_W-1:0]      lo_cfg,
  output logic [NCH-1:0][VAL_W-1:0]      cnt_cfg,
  output logic [NCH-1:0]                 en_mask
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_hi, wr_lo, wr_cnt;
    assign wr_hi  = cmd_wr && (cmd_code == hi_code(g));
    assign wr_lo  = cmd_wr && (cmd_code == lo_code(g));
    assign wr_cnt = cmd_wr && (cmd_code == cnt_code(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_cfg[g]  <= VAL_W'(1);
        lo_cfg[g]  <= VAL_W'(1);
        cnt_cfg[g] <= '0;
      end else begin
        if (wr_hi)  hi_cfg[g]  <= clamp_len(cmd_val);
        if (wr_lo)  lo_cfg[g]  <= clamp_len(cmd_val);
        if (wr_cnt) cnt_cfg[g] <= cmd_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_mask <= '0;
    end else if (cmd_wr && cmd_code == CODE_MASK) begin
      en_mask <= cmd_val[NCH-1:0];
    end
  end

  always_comb begin
    query_data = '0;
    if (query_code == CODE_MASK) query_data = VAL_W'(en_mask);
    for (int ch = 0; ch < NCH; ch++) begin
      if (query_code == hi_code(ch))  query_data = hi_cfg[ch];
      if (query_code == lo_code(ch))  query_data = lo_cfg[ch];
      if (query_code == cnt_code(ch)) query_data = cnt_cfg[ch];
    end
  end
endmodule

// File: rtl/burst_channel.sv
module burst_channel
  import pulse_burst_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 12500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [VAL_W-1:0] hi_len,
  input  logic [VAL_W-1:0] lo_len,
  input  logic [VAL_W-1:0] burst_len,
  output logic             level,
  output logic             done,
  output logic             start_evt,
  output logic [VAL_W-1:0] act_cnt
);
  logic             en_q;
  logic             tick;
  logic             restart;
  phase_t           phase;
  logic [VAL_W-1:0] remain;
  logic [VAL_W-1:0] emitted;
  logic [VAL_W-1:0] act_hi, act_lo;
  logic             phase_end;

  assign start_evt = enable && !en_q;
  assign restart   = !enable || start_evt;
  assign phase_end = tick && (remain <= VAL_W'(1));

  unit_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      phase   <= PH_IDLE;
      remain  <= '0;
      emitted <= '0;
      done    <= 1'b0;
      act_hi  <= VAL_W'(1);
      act_lo  <= VAL_W'(1);
      act_cnt <= '0;
    end else begin
      en_q <= enable;
      if (!enable) begin
        phase   <= PH_IDLE;
        remain  <= '0;
        emitted <= '0;
        done    <= 1'b0;
      end else if (start_evt) begin
        act_hi  <= hi_len;
        act_lo  <= lo_len;
        act_cnt <= burst_len;
        phase   <= PH_HIGH;
        remain  <= hi_len;
        emitted <= '0;
        done    <= 1'b0;
      end else if (tick) begin
        unique case (phase)
          PH_HIGH: begin
            if (phase_end) begin
              emitted <= emitted + VAL_W'(1);
              if (last_pulse(act_cnt, emitted)) begin
                phase <= PH_DONE;
                done  <= 1'b1;
              end else begin
                phase  <= PH_LOW;
                remain <= act_lo;
              end
            end else begin
              remain <= remain - VAL_W'(1);
            end
          end
          PH_LOW: begin
            if (phase_end) begin
              phase  <= PH_HIGH;
              remain <= act_hi;
            end else begin
              remain <= remain - VAL_W'(1);
            end
          end
          default: begin
            remain <= remain;
          end
        endcase
      end
    end
  end

  assign level = enable && (phase == PH_HIGH);
endmodule

// File: rtl/dual_pulse_burst.sv
module dual_pulse_burst
  import pulse_burst_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 12500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [7:0]  cmd_code,
  input  logic [15:0] cmd_val,
  input  logic [7:0]  query_code,
  output logic [15:0] query_data,
  output logic [1:0]  pulse_out,
  output logic [1:0]  burst_done
);
  logic [NCH-1:0][VAL_W-1:0] hi_cfg, lo_cfg, cnt_cfg, act_cnt;
  logic [NCH-1:0]            en_mask;
  logic [NCH-1:0]            start_evt;

  cfg_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_code   (cmd_code),
    .cmd_val    (cmd_val),
    .query_code (query_code),
    .query_data (query_data),
    .hi_cfg     (hi_cfg),
    .lo_cfg     (lo_cfg),
    .cnt_cfg    (cnt_cfg),
    .en_mask    (en_mask)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    burst_channel #(.TICK_CYCLES(TICK_CYCLES)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (en_mask[g]),
      .hi_len    (hi_cfg[g]),
      .lo_len    (lo_cfg[g]),
      .burst_len (cnt_cfg[g]),
      .level     (pulse_out[g]),
      .done      (burst_done[g]),
      .start_evt (start_evt[g]),
      .act_cnt   (act_cnt[g])
    );
  end
endmodule

// File: rtl/dual_pulse_burst_chk.sv
module dual_pulse_burst_chk
  import pulse_burst_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_wr,
  input logic [CODE_W-1:0]         cmd_code,
  input logic [VAL_W-1:0]          cmd_val,
  input logic [NCH-1:0]            en_mask,
  input logic [NCH-1:0]            pulse_out,
  input logic [NCH-1:0]            burst_done,
  input logic [NCH-1:0]            start_evt,
  input logic [NCH-1:0][VAL_W-1:0] hi_cfg,
  input logic [NCH-1:0][VAL_W-1:0] lo_cfg,
  input logic [NCH-1:0][VAL_W-1:0] cnt_cfg,
  input logic [NCH-1:0][VAL_W-1:0] act_cnt
);
  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_code == CODE_MASK |=> en_mask == $past(cmd_val[NCH-1:0]));

  assert_unknown_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !known_code(cmd_code) |=>
      $stable(hi_cfg) && $stable(lo_cfg) && $stable(cnt_cfg) && $stable(en_mask));

  for (genvar g = 0; g < NCH; g++) begin : g_a
    assert_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_code == hi_code(g) && cmd_val != '0 |=> hi_cfg[g] == $past(cmd_val));

    assert_zero_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_code == lo_code(g) && cmd_val == '0 |=> lo_cfg[g] == VAL_W'(1));

    assert_start_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_mask[g]) |=> pulse_out[g]);

    assert_start_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt[g] |=> !start_evt[g]);

    assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done[g] |-> !pulse_out[g]);

    assert_done_finite_R6: assert property (@(posedge clk) disable iff (!rst_n)
      burst_done[g] |-> act_cnt[g] != '0);

    assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_mask[g] && !$past(en_mask[g]) |-> !burst_done[g] && !pulse_out[g]);
  end
endmodule

bind dual_pulse_burst dual_pulse_burst_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_wr     (cmd_wr),
  .cmd_code   (cmd_code),
  .cmd_val    (cmd_val),
  .en_mask    (en_mask),
  .pulse_out  (pulse_out),
  .burst_done (burst_done),
  .start_evt  (start_evt),
  .hi_cfg     (hi_cfg),
  .lo_cfg     (lo_cfg),
  .cnt_cfg    (cnt_cfg),
  .act_cnt    (act_cnt)
);

// File: tb/dual_pulse_burst_bench.sv
module dual_pulse_burst_bench;
  localparam int TICK = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic [15:0] cmd_val = '0;
  logic [7:0]  query_code = '0;
  logic [15:0] query_data;
  logic [1:0]  pulse_out;
  logic [1:0]  burst_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dual_pulse_burst #(.TICK_CYCLES(TICK)) u_dual_pulse_burst (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .cmd_val(cmd_val), .query_code(query_code), .query_data(query_data),
    .pulse_out(pulse_out), .burst_done(burst_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic send(input logic [7:0] code, input logic [15:0] val);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_code = code; cmd_val = val;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_code = '0; cmd_val = '0;
  endtask

  task automatic expect_q(input logic [7:0] code, input int exp, input string req);
    query_code = code;
    #1;
    check(query_data == 16'(exp), req, query_data, exp);
  endtask

  // counts consecutive samples at level lvl, after first waiting for that level
  task automatic run_len(input int ch, input bit lvl, output int w);
    int guard = 0;
    w = 0;
    while (pulse_out[ch] != lvl && guard < 4000) begin @(negedge clk); guard++; end
    while (pulse_out[ch] == lvl && w < 4000) begin w++; @(negedge clk); end
  endtask

  task automatic count_rises(input int ch, input int cycles, output int n);
    bit prev = pulse_out[ch];
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pulse_out[ch] && !prev) n++;
      prev = pulse_out[ch];
    end
  endtask

  task automatic t_reset;
    check(pulse_out == 2'b00, "R1 outputs", pulse_out, 0);
    check(burst_done == 2'b00, "R1 done", burst_done, 0);
    expect_q(8'h10, 1, "R1 hi0");
    expect_q(8'h13, 1, "R1 lo1");
    expect_q(8'h15, 0, "R1 cnt1");
    expect_q(8'h1F, 0, "R1 mask");
  endtask

  task automatic t_regs;
    send(8'h10, 16'hFFFF); expect_q(8'h10, 16'hFFFF, "R2 hi0 max");
    send(8'h12, 16'd7);    expect_q(8'h12, 7, "R2 hi1");
    send(8'h11, 16'd0);    expect_q(8'h11, 1, "R3 lo0 zero->1");
    send(8'h12, 16'd0);    expect_q(8'h12, 1, "R3 hi1 zero->1");
    send(8'h14, 16'd0);    expect_q(8'h14, 0, "R2 cnt0 zero kept");
    send(8'h15, 16'h1234); expect_q(8'h15, 16'h1234, "R2 cnt1");
    send(8'h1F, 16'hFFFE); expect_q(8'h1F, 2, "R4 mask bits");
    send(8'h1F, 16'h0000); expect_q(8'h1F, 0, "R4 mask clear");
  endtask

  task automatic t_continuous;
    int w, n;
    send(8'h10, 16'd2); send(8'h11, 16'd3); send(8'h14, 16'd0);
    send(8'h1F, 16'h0001);
    check(pulse_out[0] == 1'b0, "R5 not yet high", pulse_out[0], 0);
    @(negedge clk);
    check(pulse_out[0] == 1'b1, "R5 high after start", pulse_out[0], 1);
    run_len(0, 1'b1, w); check(w == 2 * TICK, "R5 R12 high width", w, 2 * TICK);
    run_len(0, 1'b0, w); check(w == 3 * TICK, "R5 R12 low width", w, 3 * TICK);
    count_rises(0, 200, n); check(n >= 9, "R6 keeps running", n, 10);
    check(burst_done[0] == 1'b0, "R6 no done", burst_done[0], 0);
    send(8'h1F, 16'h0000);
  endtask

  task automatic t_burst;
    int n, w;
    send(8'h10, 16'd1); send(8'h11, 16'd1); send(8'h14, 16'd3);
    send(8'h1F, 16'h0001);
    count_rises(0, 120, n);
    check(n == 3, "R7 pulse count", n, 3);
    check(burst_done[0] == 1'b1, "R7 done set", burst_done[0], 1);
    check(pulse_out[0] == 1'b0, "R7 output low", pulse_out[0], 0);
    send(8'h1F, 16'h0000);
    check(pulse_out[0] == 1'b0, "R8 low on disable", pulse_out[0], 0);
    @(negedge clk);
    check(burst_done[0] == 1'b0, "R8 done cleared", burst_done[0], 0);
    send(8'h1F, 16'h0001);
    @(negedge clk);
    run_len(0, 1'b1, w); check(w == TICK, "R8 restart high", w, TICK);
    count_rises(0, 120, n);
    check(n == 2, "R8 full count again", n, 2);
    send(8'h1F, 16'h0000);
  endtask

  task automatic t_abort;
    int w;
    send(8'h10, 16'd10); send(8'h14, 16'd0);
    send(8'h1F, 16'h0001);
    repeat (3) @(negedge clk);
    check(pulse_out[0] == 1'b1, "R8 mid high", pulse_out[0], 1);
    send(8'h1F, 16'h0000);
    check(pulse_out[0] == 1'b0, "R8 forced low", pulse_out[0], 0);
    send(8'h1F, 16'h0001);
    @(negedge clk);
    run_len(0, 1'b1, w); check(w == 10 * TICK, "R8 fresh high phase", w, 10 * TICK);
    send(8'h1F, 16'h0000);
  endtask

  task automatic t_live_write;
    int w;
    send(8'h10, 16'd2); send(8'h11, 16'd2); send(8'h14, 16'd0);
    send(8'h1F, 16'h0001);
    send(8'h10, 16'd5);
    expect_q(8'h10, 5, "R2 stored while running");
    run_len(0, 1'b0, w);
    run_len(0, 1'b1, w); check(w == 2 * TICK, "R9 old high kept", w, 2 * TICK);
    send(8'h1F, 16'h0000);
    send(8'h1F, 16'h0001);
    @(negedge clk);
    run_len(0, 1'b1, w); check(w == 5 * TICK, "R9 new high at enable", w, 5 * TICK);
    send(8'h1F, 16'h0000);
  endtask

  task automatic t_independent;
    int w, n;
    send(8'h10, 16'd2); send(8'h11, 16'd2); send(8'h14, 16'd0);
    send(8'h12, 16'd3); send(8'h13, 16'd1); send(8'h15, 16'd2);
    expect_q(8'h10, 2, "R10 ch0 hi untouched");
    send(8'h1F, 16'h0003);
    @(negedge clk);
    check(pulse_out == 2'b11, "R10 both start high", pulse_out, 3);
    run_len(1, 1'b1, w); check(w == 3 * TICK, "R10 ch1 high width", w, 3 * TICK);
    count_rises(1, 100, n); check(n == 1, "R10 ch1 second pulse", n, 1);
    check(burst_done == 2'b10, "R10 only ch1 done", burst_done, 2);
    count_rises(0, 40, n); check(n >= 2, "R10 ch0 still runs", n, 2);
    send(8'h1F, 16'h0000);
  endtask

  task automatic t_unknown;
    int n;
    send(8'h10, 16'd4); send(8'h11, 16'd4);
    send(8'h16, 16'hABCD); send(8'h20, 16'h0003); send(8'h0F, 16'h0001);
    expect_q(8'h10, 4, "R11 hi0 kept");
    expect_q(8'h11, 4, "R11 lo0 kept");
    expect_q(8'h15, 2, "R11 cnt1 kept");
    expect_q(8'h1F, 0, "R11 mask kept");
    expect_q(8'h16, 0, "R11 unknown query");
    count_rises(0, 20, n); check(n == 0 && pulse_out == 2'b00, "R11 outputs idle", n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_continuous();
    t_burst();
    t_abort();
    t_live_write();
    t_independent();
    t_unknown();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule